// File: doc/BRIEF.md
# Hamming 7,4 Single-Error Corrector

This block protects 4-bit data with a 7-bit even-parity Hamming code. Its encoder path takes a data nibble and builds a seven-position codeword with check bits at the power-of-two positions. Its decoder path takes a received seven-position word and recomputes the three group checks. The three checks form a syndrome, and a non-zero syndrome is the 1-based position of the one bit to invert. The decoder returns the repaired codeword, the data nibble taken from it, the syndrome and a flag that shows whether a bit was inverted.

Both paths carry `LANES` independent lanes side by side on flat buses. Lane k of each bus sits at bits `[k*W +: W]`, where W is the width of one lane. A parameter sets the output stage. With `REGISTERED = 1` each path registers its results one clock after its input strobe and raises a matching output strobe. With `REGISTERED = 0` the outputs follow the inputs in the same cycle.

Top module: `ham74_codec`

## Requirements
- R1: In a codeword, bit i-1 holds position i (positions 1 to 7). Data bits d[0], d[1], d[2] and d[3] go to positions 3, 5, 6 and 7. The check bits go to positions 1, 2 and 4.
- R2: The check bit at position 1 gives even parity over positions 1, 3, 5 and 7. The check bit at position 2 gives even parity over positions 2, 3, 6 and 7. The check bit at position 4 gives even parity over positions 4, 5, 6 and 7.
- R3: The decoder syndrome is {c4, c2, c1}. Each c is 1 when its group (as listed in R2) has odd parity in the received word. The syndrome appears on `dec_synd_o`.
- R4: When the syndrome is non-zero, the decoder inverts the bit at the position the syndrome names and drives that lane's `dec_fixed_o` bit high.
- R5: When the syndrome is zero, the received word passes through unchanged and that lane's `dec_fixed_o` bit is low.
- R6: `dec_data_o` is positions {7, 6, 5, 3} of the repaired word, MSB first.
- R7: With `REGISTERED = 1`, the results for an input accepted with its valid strobe appear on the next clock, together with a high output valid. A low input valid gives a low output valid on the next clock.
- R8: While an input valid is low, that path's registered data outputs keep their last values, whatever is on its inputs.
- R9: While reset is asserted, both output valids are low and every registered data output is zero.
- R10: Lanes are independent. A bit error in one lane changes no output of another lane.
- R11: Data 1011 encodes to 1010101 (position 7 written first). A received word of 1000101 gives syndrome 101 and is repaired to 1010101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 4*LANES | Data nibbles, one per lane |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_code_o | output | 7*LANES | Encoded codewords |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | 7*LANES | Received words |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_code_o | output | 7*LANES | Repaired codewords |
| dec_data_o | output | 4*LANES | Data taken from the repaired words |
| dec_synd_o | output | 3*LANES | Syndrome of each received word |
| dec_fixed_o | output | LANES | Per lane, high when a bit was inverted |

## Verification
A wrong group mask or a wrong data placement in the encoder gives a wrong codeword on the first strobe that carries an affected nibble. The bench drives all 16 nibbles, so any such fault shows at the ports within a few dozen cycles. A fault in the syndrome or in the bit-flip selection shows as a wrong syndrome, a wrong repaired word or a wrong flag one clock after the received word. Every one of the 128 possible received words is applied, so each syndrome value and each flip position is reached. A register that loads or clears at the wrong time shows as a wrong strobe, or as an output that moves during a cycle with the strobe low.

// File: rtl/ham74_pkg.sv
package ham74_pkg;

   localparam int PAR_W  = 3;
   localparam int CODE_W = (1 << PAR_W) - 1;
   localparam int DATA_W = CODE_W - PAR_W;

   typedef logic [DATA_W-1:0] nib_t;
   typedef logic [CODE_W-1:0] cw_t;
   typedef logic [PAR_W-1:0]  syn_t;

   // Position p (1-based) carries a check bit when p is a power of two.
   function automatic logic is_par_pos(input int pos);
      return ((pos & (pos - 1)) == 0);
   endfunction

   // Index of the data bit stored at a non-check position.
   function automatic int data_idx(input int pos);
      int cnt;
      cnt = 0;
      for (int q = 1; q < pos; q++) begin
         if (!is_par_pos(q)) cnt++;
      end
      return cnt;
   endfunction

   // Positions watched by check group k (bit k of the position index).
   function automatic cw_t cover_mask(input int k);
      cw_t m;
      m = '0;
      for (int pos = 1; pos <= CODE_W; pos++) begin
         if (((pos >> k) & 1) != 0) m = m | (cw_t'(1) << (pos - 1));
      end
      return m;
   endfunction

   // Group checks of a word, used by the embedded checks.
   function automatic syn_t check_of(input cw_t w);
      syn_t s;
      s = '0;
      for (int k = 0; k < PAR_W; k++) begin
         s = s | (syn_t'(^(w & cover_mask(k))) << k);
      end
      return s;
   endfunction

endpackage

// File: rtl/ham74_enc.sv
module ham74_enc
   import ham74_pkg::*;
(
   input  nib_t data_i,
   output cw_t  code_o
);

   cw_t dvec;

   for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
      if (is_par_pos(p)) begin : g_par
         localparam int  K = $clog2(p);
         localparam cw_t M = cover_mask(K);
         assign dvec[p-1]   = 1'b0;
         assign code_o[p-1] = ^(dvec & M);
      end else begin : g_dat
         localparam int I = data_idx(p);
         assign dvec[p-1]   = data_i[I];
         assign code_o[p-1] = data_i[I];
      end
   end

endmodule

// File: rtl/ham74_synd.sv
module ham74_synd
   import ham74_pkg::*;
(
   input  cw_t  code_i,
   output syn_t syn_o
);

   for (genvar k = 0; k < PAR_W; k++) begin : g_chk
      localparam cw_t M = cover_mask(k);
      assign syn_o[k] = ^(code_i & M);
   end

endmodule

// File: rtl/ham74_fix.sv
module ham74_fix
   import ham74_pkg::*;
(
   input  cw_t  code_i,
   input  syn_t syn_i,
   output cw_t  code_o,
   output nib_t data_o,
   output logic fixed_o
);

   cw_t flip;

   for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
      assign flip[p-1] = (syn_i == syn_t'(p));
      if (!is_par_pos(p)) begin : g_dat
         localparam int I = data_idx(p);
         assign data_o[I] = code_o[p-1];
      end
   end

   assign code_o  = code_i ^ flip;
   assign fixed_o = |flip;

endmodule

// File: rtl/ham74_codec.sv
module ham74_codec
   import ham74_pkg::*;
#(
   parameter int LANES      = 2,
   parameter int REGISTERED = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enc_valid_i,
   input  logic [LANES*DATA_W-1:0] enc_data_i,
   output logic                    enc_valid_o,
   output logic [LANES*CODE_W-1:0] enc_code_o,
   input  logic                    dec_valid_i,
   input  logic [LANES*CODE_W-1:0] dec_code_i,
   output logic                    dec_valid_o,
   output logic [LANES*CODE_W-1:0] dec_code_o,
   output logic [LANES*DATA_W-1:0] dec_data_o,
   output logic [LANES*PAR_W-1:0]  dec_synd_o,
   output logic [LANES-1:0]        dec_fixed_o
);

   localparam int EW = LANES * DATA_W;
   localparam int CW = LANES * CODE_W;
   localparam int SW = LANES * PAR_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("ham74_codec: LANES must be at least 1");
   end
   if (REGISTERED != 0 && REGISTERED != 1) begin : g_bad_reg
      $error("ham74_codec: REGISTERED must be 0 or 1");
   end
   if (CODE_W != 7 || DATA_W != 4) begin : g_bad_code
      $error("ham74_codec: package must describe a 7,4 code");
   end

   logic [CW-1:0] enc_flat;
   logic [CW-1:0] fix_flat;
   logic [EW-1:0] dat_flat;
   logic [SW-1:0] syn_flat;
   logic [LANES-1:0] fixed_flat;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      cw_t  enc_cw;
      cw_t  rx_cw;
      cw_t  fix_cw;
      syn_t syn;
      nib_t dat;
      logic fixed;

      assign rx_cw = dec_code_i[g*CODE_W +: CODE_W];

      ham74_enc u_enc (
         .data_i (enc_data_i[g*DATA_W +: DATA_W]),
         .code_o (enc_cw)
      );

      ham74_synd u_synd (
         .code_i (rx_cw),
         .syn_o  (syn)
      );

      ham74_fix u_fix (
         .code_i  (rx_cw),
         .syn_i   (syn),
         .code_o  (fix_cw),
         .data_o  (dat),
         .fixed_o (fixed)
      );

      assign enc_flat[g*CODE_W +: CODE_W] = enc_cw;
      assign fix_flat[g*CODE_W +: CODE_W] = fix_cw;
      assign dat_flat[g*DATA_W +: DATA_W] = dat;
      assign syn_flat[g*PAR_W +: PAR_W]   = syn;
      assign fixed_flat[g]                = fixed;

      // R2: a fresh codeword passes every group check
      p_enc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
         check_of(enc_cw) == '0);

      // R4: the repaired word passes every group check
      p_fix_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
         check_of(fix_cw) == '0);

      // R4: repair touches at most one bit
      p_one_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(fix_cw ^ rx_cw) <= 1);

      // R5: the flag is high exactly when the word was altered
      p_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
         fixed == (fix_cw != rx_cw));
   end

   if (REGISTERED == 1) begin : g_reg
      logic          enc_v_q;
      logic [CW-1:0] enc_code_q;
      logic          dec_v_q;
      logic [CW-1:0] dec_code_q;
      logic [EW-1:0] dec_data_q;
      logic [SW-1:0] dec_synd_q;
      logic [LANES-1:0] dec_fixed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            enc_v_q    <= 1'b0;
            enc_code_q <= '0;
         end else begin
            enc_v_q <= enc_valid_i;
            if (enc_valid_i) enc_code_q <= enc_flat;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dec_v_q     <= 1'b0;
            dec_code_q  <= '0;
            dec_data_q  <= '0;
            dec_synd_q  <= '0;
            dec_fixed_q <= '0;
         end else begin
            dec_v_q <= dec_valid_i;
            if (dec_valid_i) begin
               dec_code_q  <= fix_flat;
               dec_data_q  <= dat_flat;
               dec_synd_q  <= syn_flat;
               dec_fixed_q <= fixed_flat;
            end
         end
      end

      assign enc_valid_o = enc_v_q;
      assign enc_code_o  = enc_code_q;
      assign dec_valid_o = dec_v_q;
      assign dec_code_o  = dec_code_q;
      assign dec_data_o  = dec_data_q;
      assign dec_synd_o  = dec_synd_q;
      assign dec_fixed_o = dec_fixed_q;

      // R7: output strobes follow input strobes by one clock
      p_enc_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
         enc_valid_i |=> enc_valid_o);
      p_dec_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !dec_valid_i |=> !dec_valid_o);

      // R8: outputs hold while the input strobe is low
      p_enc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !enc_valid_i |=> $stable(enc_code_o));
      p_dec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !dec_valid_i |=> ($stable(dec_code_o) && $stable(dec_fixed_o)));
   end else begin : g_comb
      assign enc_valid_o = enc_valid_i;
      assign enc_code_o  = enc_flat;
      assign dec_valid_o = dec_valid_i;
      assign dec_code_o  = fix_flat;
      assign dec_data_o  = dat_flat;
      assign dec_synd_o  = syn_flat;
      assign dec_fixed_o = fixed_flat;
   end

endmodule

// File: tb/ham74_codec_test.sv
module ham74_codec_test;

   localparam int CLK_PERIOD = 10;
   localparam int LN = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            enc_valid_i = 1'b0;
   logic [LN*4-1:0] enc_data_i = '0;
   logic            enc_valid_o;
   logic [LN*7-1:0] enc_code_o;
   logic            dec_valid_i = 1'b0;
   logic [LN*7-1:0] dec_code_i = '0;
   logic            dec_valid_o;
   logic [LN*7-1:0] dec_code_o;
   logic [LN*4-1:0] dec_data_o;
   logic [LN*3-1:0] dec_synd_o;
   logic [LN-1:0]   dec_fixed_o;

   int n_chk = 0;
   int n_fail = 0;

   ham74_codec #(.LANES(LN), .REGISTERED(1)) uut (
      .clk(clk), .rst_n(rst_n),
      .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
      .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
      .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
      .dec_valid_o(dec_valid_o), .dec_code_o(dec_code_o),
      .dec_data_o(dec_data_o), .dec_synd_o(dec_synd_o),
      .dec_fixed_o(dec_fixed_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [6:0] ref_enc(input logic [3:0] d);
      logic p1, p2, p4;
      p1 = d[0] ^ d[1] ^ d[3];
      p2 = d[0] ^ d[2] ^ d[3];
      p4 = d[1] ^ d[2] ^ d[3];
      return {d[3], d[2], d[1], p4, d[0], p2, p1};
   endfunction

   function automatic logic [2:0] ref_syn(input logic [6:0] w);
      return {w[3]^w[4]^w[5]^w[6], w[1]^w[2]^w[5]^w[6], w[0]^w[2]^w[4]^w[6]};
   endfunction

   function automatic logic [6:0] ref_fix(input logic [6:0] w);
      logic [2:0] s;
      s = ref_syn(w);
      if (s == 3'd0) return w;
      return w ^ (7'd1 << (s - 3'd1));
   endfunction

   function automatic logic [3:0] ref_dat(input logic [6:0] w);
      return {w[6], w[5], w[4], w[2]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic [LN*7-1:0] x_enc, x_code;
   logic [LN*4-1:0] x_dat;
   logic [LN*3-1:0] x_syn;
   logic [LN-1:0]   x_fix;

   // Apply one strobe on both paths, then check one clock later.
   task automatic apply(input logic [LN*4-1:0] ed, input logic [LN*7-1:0] dc);
      @(negedge clk);
      enc_data_i  = ed;
      dec_code_i  = dc;
      enc_valid_i = 1'b1;
      dec_valid_i = 1'b1;
      for (int g = 0; g < LN; g++) begin
         x_enc[g*7 +: 7]  = ref_enc(ed[g*4 +: 4]);
         x_syn[g*3 +: 3]  = ref_syn(dc[g*7 +: 7]);
         x_code[g*7 +: 7] = ref_fix(dc[g*7 +: 7]);
         x_dat[g*4 +: 4]  = ref_dat(ref_fix(dc[g*7 +: 7]));
         x_fix[g]         = (ref_syn(dc[g*7 +: 7]) != 3'd0);
      end
      @(negedge clk);
      chk("R7 enc valid", 32'(enc_valid_o), 32'd1);
      chk("R7 dec valid", 32'(dec_valid_o), 32'd1);
      chk("R1 R2 codeword", 32'(enc_code_o), 32'(x_enc));
      chk("R3 syndrome", 32'(dec_synd_o), 32'(x_syn));
      chk("R4 R5 repaired word", 32'(dec_code_o), 32'(x_code));
      chk("R6 data", 32'(dec_data_o), 32'(x_dat));
      chk("R4 R5 flag", 32'(dec_fixed_o), 32'(x_fix));
      enc_valid_i = 1'b0;
      dec_valid_i = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      chk("R9 enc valid in reset", 32'(enc_valid_o), 32'd0);
      chk("R9 dec valid in reset", 32'(dec_valid_o), 32'd0);
      chk("R9 enc code in reset", 32'(enc_code_o), 32'd0);
      chk("R9 dec outputs in reset", 32'({dec_code_o, dec_data_o, dec_synd_o, dec_fixed_o}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 worked example on lane 0
      apply({4'b0000, 4'b1011}, {7'b0000000, 7'b1000101});
      chk("R11 encode 1011", 32'(enc_code_o[6:0]), 32'(7'b1010101));
      chk("R11 syndrome", 32'(dec_synd_o[2:0]), 32'(3'b101));
      chk("R11 repaired", 32'(dec_code_o[6:0]), 32'(7'b1010101));
      chk("R11 data", 32'(dec_data_o[3:0]), 32'(4'b1011));

      // Every received word on lane 0, a different word on lane 1
      for (int w = 0; w < 128; w++) begin
         logic [6:0] a, b;
         a = 7'(w);
         b = 7'(w) ^ 7'h5A;
         apply({a[6:3], a[3:0]}, {b, a});
      end

      // Every nibble with every single-bit error position (0 = none)
      for (int d = 0; d < 16; d++) begin
         for (int e = 0; e < 8; e++) begin
            logic [3:0] d0, d1;
            logic [6:0] c0, c1;
            int e1;
            d0 = 4'(d);
            d1 = 4'(d + 5);
            e1 = (e + 3) % 8;
            c0 = ref_enc(d0) ^ ((e == 0) ? 7'd0 : (7'd1 << (e - 1)));
            c1 = ref_enc(d1) ^ ((e1 == 0) ? 7'd0 : (7'd1 << (e1 - 1)));
            apply({d1, d0}, {c1, c0});
            chk("R4 data recovered lane0", 32'(dec_data_o[3:0]), 32'(d0));
            chk("R10 data recovered lane1", 32'(dec_data_o[7:4]), 32'(d1));
            chk("R4 clean word lane0", 32'(dec_code_o[6:0]), 32'(ref_enc(d0)));
         end
      end

      // R10: error only in lane 1, lane 0 untouched
      apply({4'h3, 4'hC}, {ref_enc(4'h3) ^ 7'b0100000, ref_enc(4'hC)});
      chk("R10 lane flags", 32'(dec_fixed_o), 32'(2'b10));
      chk("R10 lane0 syndrome", 32'(dec_synd_o[2:0]), 32'd0);
      chk("R10 lane1 syndrome", 32'(dec_synd_o[5:3]), 32'd6);

      // R8: strobe low with new inputs, outputs keep previous values
      @(negedge clk);
      enc_data_i  = ~enc_data_i;
      dec_code_i  = ~dec_code_i;
      @(negedge clk);
      chk("R7 enc valid low", 32'(enc_valid_o), 32'd0);
      chk("R7 dec valid low", 32'(dec_valid_o), 32'd0);
      chk("R8 enc hold", 32'(enc_code_o), 32'(x_enc));
      chk("R8 dec code hold", 32'(dec_code_o), 32'(x_code));
      chk("R8 dec flag hold", 32'(dec_fixed_o), 32'(x_fix));
      chk("R8 dec data hold", 32'(dec_data_o), 32'(x_dat));

      // R9: reset clears registered outputs again
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 outputs after reset", 32'({enc_valid_o, dec_valid_o, dec_fixed_o, dec_synd_o}), 32'd0);
      chk("R9 codes after reset", 32'(enc_code_o | dec_code_o), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule